// File: doc/BRIEF.md
# NAND Page Hamming Parity Generator

This block sits on the byte path between a NAND flash data register and the flash device. It computes single-error-correcting Hamming parity over the data bytes that actually cross the path. Each 256-byte chunk yields three parity bytes, so a 512-byte page yields six. Software drives it through a two-bit mode value: clear the accumulators, hold, accumulate, or read out. In read-out mode the stored parity comes back one byte per read of the data register, in a fixed permuted order inside each chunk's group of three.

To arm the block before a page transfer, software sets clear, then hold, then accumulate. To collect the result after the transfer, it sets hold, then read-out, reads three bytes per chunk, and returns to hold. The parity is stored inverted, so an erased (all-ones) page produces all-ones parity. Software compares the parity it reads back with the parity stored in the spare area, and uses the difference to find and fix one flipped bit per chunk.

Top module: `nand_ecc_gen`

## Requirements
- R1: After `rst_n` is released, the mode is hold (00), every accumulator is zero and the read pointer is at the first byte of chunk 0. `par_out` is 8'hFF.
- R2: The mode written on `mode_val` with `mode_wr` takes effect at the next clock edge, with this encoding: 2'b11 clear, 2'b00 hold, 2'b01 accumulate, 2'b10 read-out. Outside read-out, `par_out` is 8'hFF.
- R3: A byte is accumulated only when the mode is 01, `byte_vld` is 1, `cle` is 0 and `ale` is 0. Command bytes, address bytes and idle cycles leave the parity unchanged.
- R4: Take the line parity LP[15:0] of a chunk. For k = 0..7, LP[2k+1] is the XOR of the bit-parities of the bytes whose in-chunk index has bit k set. LP[2k] is the same XOR over the bytes whose index has bit k clear. Parity byte 0 is ~LP[7:0] and parity byte 1 is ~LP[15:8].
- R5: Take the column parity CP[5:0] over all bytes of a chunk. CP0 covers data bits 0,2,4,6 and CP1 covers bits 1,3,5,7. CP2 covers bits 0,1,4,5 and CP3 covers bits 2,3,6,7. CP4 covers bits 0..3 and CP5 covers bits 4..7. Parity byte 2 is ~{CP5..CP0} in bits 7:2, with bits 1:0 read as 1. An all-ones page gives all 8'hFF parity.
- R6: After 256 accumulated bytes, accumulation moves to chunk 1. Bytes after the 512th are ignored.
- R7: In read-out mode, `par_out` presents parity byte 1, then byte 0, then byte 2 of chunk 0, then the same three bytes of chunk 1. Each `rd_req` cycle advances the pointer by one position, and after the sixth byte it wraps to the start.
- R8: While the mode is clear (11), the accumulators, the byte counters and the read pointer are held at their start values.
- R9: In hold mode (00), the accumulators and counters keep their values whatever the data path does.
- R10: A single flipped data bit in a chunk changes exactly 11 of the 22 parity bits. The changed odd LP bits spell the byte index, and the changed odd CP bits spell the bit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load `mode_val` into the mode register |
| mode_val | input | 2 | Mode value (11 clear, 00 hold, 01 accumulate, 10 read-out) |
| byte_vld | input | 1 | A byte crosses the flash data path this cycle |
| byte_in | input | 8 | Byte on the data path |
| cle | input | 1 | Current transfer is a command byte |
| ale | input | 1 | Current transfer is an address byte |
| rd_req | input | 1 | Data-register read in read-out mode; advances the pointer |
| par_out | output | 8 | Parity byte at the read pointer (8'hFF outside read-out) |

## Verification
The bench goes after the places where the parity is easy to get subtly wrong.

- **Byte gating.** Command, address and held bytes are mixed into the stream. A gate that let any of them through would corrupt both line and column parity for the chunk.
- **Chunk rollover.** It crosses the boundary at byte 256 and pushes bytes past 512. A counter off by one would smear a byte into the wrong chunk, or let a late byte overwrite finished parity.
- **Read-out order and pointer return.** It reads the 1-0-2 order and wraps the pointer. It also clears the block in the middle of a read, so a pointer that skipped the return to start would hand back the wrong byte of the group.
- **Single-bit syndrome.** It flips one bit and decodes the syndrome. A wrong line mask or column mask would give a syndrome that points at the wrong byte or bit.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned CHUNK_BYTES = 256;
  localparam int unsigned IDX_W       = $clog2(CHUNK_BYTES);
  localparam int unsigned LP_W        = 2 * IDX_W;
  localparam int unsigned CP_W        = 6;
  localparam int unsigned GROUP_LEN   = 3;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  // Column parity of one byte: [5] hi nibble, [4] lo nibble, [3] bit pairs 2,3,6,7,
  // [2] bit pairs 0,1,4,5, [1] odd bits, [0] even bits.
  function automatic logic [CP_W-1:0] col_parity(input logic [BYTE_W-1:0] b);
    return {^(b & 8'hF0), ^(b & 8'h0F), ^(b & 8'hCC),
            ^(b & 8'h33), ^(b & 8'hAA), ^(b & 8'h55)};
  endfunction

  // Which line-parity bits one byte index feeds: odd bit for an index bit of 1, even for 0.
  function automatic logic [LP_W-1:0] line_mask(input logic [IDX_W-1:0] idx);
    logic [LP_W-1:0] m;
    for (int k = 0; k < IDX_W; k++) begin
      m[2*k+1] = idx[k];
      m[2*k]   = ~idx[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/nand_ecc_mode.sv
module nand_ecc_mode
  import nand_ecc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_wr,
  input  logic [1:0] mode_val,
  input  logic      byte_vld,
  input  logic      cle,
  input  logic      ale,
  input  logic      rd_req,
  output ecc_mode_e mode_q,
  output logic      acc_ev,
  output logic      clr_ev,
  output logic      rd_step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_wr) mode_q <= ecc_mode_e'(mode_val);
  end

  assign acc_ev  = (mode_q == MODE_ACC) && byte_vld && !cle && !ale;
  assign clr_ev  = (mode_q == MODE_CLR);
  assign rd_step = (mode_q == MODE_READ) && rd_req;
endmodule

// File: rtl/nand_ecc_counter.sv
module nand_ecc_counter
  import nand_ecc_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 2,
  localparam int unsigned GRP_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ev,
  input  logic             clr_ev,
  output logic [IDX_W-1:0] byte_idx,
  output logic [GRP_W-1:0] chunk_sel,
  output logic             full
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHUNK_BYTES - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_CHUNKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_idx  <= '0;
      chunk_sel <= '0;
      full      <= 1'b0;
    end else if (clr_ev) begin
      byte_idx  <= '0;
      chunk_sel <= '0;
      full      <= 1'b0;
    end else if (acc_ev && !full) begin
      byte_idx <= byte_idx + 1'b1;
      if (byte_idx == IDX_LAST) begin
        if (chunk_sel == GRP_LAST) full <= 1'b1;
        else chunk_sel <= chunk_sel + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_ecc_acc.sv
module nand_ecc_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  output logic [LP_W-1:0]   lp,
  output logic [CP_W-1:0]   cp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp <= '0;
      cp <= '0;
    end else if (clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ (line_mask(idx) & {LP_W{^din}});
      cp <= cp ^ col_parity(din);
    end
  end
endmodule

// File: rtl/nand_ecc_readout.sv
module nand_ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 2,
  localparam int unsigned GRP_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr,
  input  logic                             step,
  input  logic                             read_on,
  input  logic [NUM_CHUNKS-1:0][LP_W-1:0]  lp_all,
  input  logic [NUM_CHUNKS-1:0][CP_W-1:0]  cp_all,
  output logic [1:0]                       pos,
  output logic [GRP_W-1:0]                 grp,
  output logic [BYTE_W-1:0]                par_out
);
  localparam logic [1:0]       POS_LAST = 2'(GROUP_LEN - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_CHUNKS - 1);

  logic [LP_W-1:0] lp_sel;
  logic [CP_W-1:0] cp_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      grp <= '0;
    end else if (clr) begin
      pos <= '0;
      grp <= '0;
    end else if (step) begin
      if (pos == POS_LAST) begin
        pos <= '0;
        grp <= (grp == GRP_LAST) ? '0 : grp + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign lp_sel = lp_all[grp];
  assign cp_sel = cp_all[grp];

  // Group order: high line byte, low line byte, column byte; stored inverted.
  always_comb begin
    if (!read_on) par_out = '1;
    else begin
      case (pos)
        2'd0:    par_out = ~lp_sel[LP_W-1 -: BYTE_W];
        2'd1:    par_out = ~lp_sel[BYTE_W-1:0];
        default: par_out = ~{cp_sel, 2'b00};
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
#(
  parameter int unsigned NUM_CHUNKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_val,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       cle,
  input  logic       ale,
  input  logic       rd_req,
  output logic [7:0] par_out
);
  localparam int unsigned GRP_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;

  ecc_mode_e        mode_q;
  logic             acc_ev, clr_ev, rd_step, full;
  logic [IDX_W-1:0] byte_idx;
  logic [GRP_W-1:0] chunk_sel, grp;
  logic [1:0]       pos;
  logic [NUM_CHUNKS-1:0][LP_W-1:0] lp_all;
  logic [NUM_CHUNKS-1:0][CP_W-1:0] cp_all;

  nand_ecc_mode u_mode (
    .clk, .rst_n, .mode_wr, .mode_val, .byte_vld, .cle, .ale, .rd_req,
    .mode_q, .acc_ev, .clr_ev, .rd_step
  );

  nand_ecc_counter #(.NUM_CHUNKS(NUM_CHUNKS)) u_cnt (
    .clk, .rst_n, .acc_ev, .clr_ev, .byte_idx, .chunk_sel, .full
  );

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    logic chunk_en;
    assign chunk_en = acc_ev && !full && (chunk_sel == GRP_W'(g));
    nand_ecc_acc u_acc (
      .clk, .rst_n, .clr(clr_ev), .en(chunk_en), .idx(byte_idx), .din(byte_in),
      .lp(lp_all[g]), .cp(cp_all[g])
    );
  end

  nand_ecc_readout #(.NUM_CHUNKS(NUM_CHUNKS)) u_rd (
    .clk, .rst_n, .clr(clr_ev), .step(rd_step), .read_on(mode_q == MODE_READ),
    .lp_all, .cp_all, .pos, .grp, .par_out
  );
endmodule

// File: rtl/nand_ecc_gen_chk.sv
module nand_ecc_gen_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned GRP_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_q,
  input logic             acc_ev,
  input logic             clr_ev,
  input logic             rd_step,
  input logic             full,
  input logic [IDX_W-1:0] byte_idx,
  input logic [GRP_W-1:0] chunk_sel,
  input logic [GRP_W-1:0] grp,
  input logic [1:0]       pos,
  input logic [7:0]       par_out
);
  assert_idle_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b10) |-> (par_out == 8'hFF));

  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ev && !clr_ev) |=> ($stable(byte_idx) && $stable(chunk_sel) && $stable(full)));

  assert_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10 && pos == 2'd2) |-> (par_out[1:0] == 2'b11));

  assert_fill_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr_ev) |=> full);

  assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos != 2'd3);

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && pos != 2'd2) |=> (pos == $past(pos) + 2'd1 && $stable(grp)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> (pos == 2'd0 && grp == '0 && byte_idx == '0 && chunk_sel == '0 && !full));

  assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> ($stable(byte_idx) && $stable(chunk_sel) && $stable(pos)));
endmodule

bind nand_ecc_gen nand_ecc_gen_chk #(.IDX_W(nand_ecc_pkg::IDX_W), .GRP_W(GRP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .acc_ev(acc_ev), .clr_ev(clr_ev),
  .rd_step(rd_step), .full(full), .byte_idx(byte_idx), .chunk_sel(chunk_sel),
  .grp(grp), .pos(pos), .par_out(par_out)
);

// File: tb/nand_ecc_gen_test.sv
module nand_ecc_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_val = 2'b00;
  logic byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic cle = 1'b0;
  logic ale = 1'b0;
  logic rd_req = 1'b0;
  logic [7:0] par_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [7:0] m_mem [512];
  int m_total = 0;
  int m_ptr = 0;
  int m_mode = 0;

  nand_ecc_gen uut (
    .clk, .rst_n, .mode_wr, .mode_val, .byte_vld, .byte_in,
    .cle, .ale, .rd_req, .par_out
  );

  always #10 clk = ~clk;

  // parity byte at read position p, computed from first principles over stored bytes
  function automatic logic [7:0] model_byte(int p);
    int g, s, n;
    logic [15:0] lp;
    logic [5:0] cp;
    logic [7:0] b;
    g = p / 3;
    s = p % 3;
    n = m_total - g * 256;
    if (n < 0) n = 0;
    if (n > 256) n = 256;
    lp = '0;
    cp = '0;
    for (int i = 0; i < n; i++) begin
      b = m_mem[g*256 + i];
      for (int j = 0; j < 16; j++)
        if (((i >> (j / 2)) & 1) == (j % 2)) lp[j] = lp[j] ^ (^b);
      for (int bit_i = 0; bit_i < 8; bit_i++)
        if (b[bit_i])
          for (int j = 0; j < 6; j++)
            if (((bit_i >> (j / 2)) & 1) == (j % 2)) cp[j] = ~cp[j];
    end
    if (s == 0) return ~lp[15:8];
    if (s == 1) return ~lp[7:0];
    return ~{cp, 2'b00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_total = 0; m_ptr = 0; m_mode = 0;
    end else begin
      if (m_mode == 3) begin
        m_total = 0; m_ptr = 0;
      end else if (m_mode == 1 && byte_vld && !cle && !ale && m_total < 512) begin
        m_mem[m_total] = byte_in;
        m_total = m_total + 1;
      end
      if (m_mode == 2 && rd_req) m_ptr = (m_ptr + 1) % 6;
      if (mode_wr) m_mode = int'(mode_val);
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e;
      e = (m_mode == 2) ? model_byte(m_ptr) : 8'hFF;
      checks++;
      if (par_out !== e) begin
        errors++;
        $display("FAIL %s per-cycle cyc=%0d actual=%h expected=%h",
                 (m_mode == 2) ? "R7" : "R2", cyc, par_out, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1'b1; mode_val = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input logic c, input logic a);
    byte_vld = 1'b1; byte_in = b; cle = c; ale = a;
    @(negedge clk);
    byte_vld = 1'b0; cle = 1'b0; ale = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] v);
    v = par_out;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic arm();
    wr_mode(2'b11); wr_mode(2'b00); wr_mode(2'b01);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  logic [7:0] v;
  logic [7:0] grp_a [6];
  logic [7:0] s0 [3];
  logic [7:0] s1 [3];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out after reset", par_out, 8'hFF);

    // R1: accumulators zero and pointer at start straight out of reset (no clear)
    wr_mode(2'b01);
    push(8'h00, 1'b0, 1'b0);
    push(8'h01, 1'b0, 1'b0);
    wr_mode(2'b00);
    chk("R2 hold mode output", par_out, 8'hFF);
    wr_mode(2'b10);
    read_byte(v); chk("R1 first read byte1", v, 8'hAA);

    // R8: clear mid-read, pointer must return to byte 1 of chunk 0
    arm();
    push(8'h00, 1'b0, 1'b0);
    push(8'h01, 1'b0, 1'b0);
    wr_mode(2'b00);
    wr_mode(2'b10);
    read_byte(v); chk("R8 pointer restart byte1", v, 8'hAA);
    read_byte(v); chk("R4 line byte0 idx1", v, 8'hA9);
    read_byte(v); chk("R5 column byte2", v, 8'hAB);
    read_byte(v); chk("R6 chunk1 untouched", v, 8'hFF);

    // main page with command/address/idle noise and a hold gap
    arm();
    for (int i = 0; i < 512; i++) begin
      logic [7:0] d;
      d = (i < 256) ? 8'((i * 37 + 11) & 255) : 8'(((i * i) + 5) ^ 8'hC3);
      if (i % 50 == 7) push(8'h5A, 1'b1, 1'b0);
      if (i % 61 == 3) push(8'hC6, 1'b0, 1'b1);
      if (i == 300) begin
        wr_mode(2'b00);
        push(8'h77, 1'b0, 1'b0);
        push(8'h12, 1'b0, 1'b0);
        wr_mode(2'b01);
      end
      push(d, 1'b0, 1'b0);
      if (i % 13 == 0) @(negedge clk);
    end
    wr_mode(2'b00);
    wr_mode(2'b10);
    for (int p = 0; p < 6; p++) begin
      logic [7:0] e;
      e = model_byte(p);
      read_byte(v);
      grp_a[p] = v;
      chk((p < 3) ? "R3 gated chunk0 R7 order" : "R9 held chunk1 R7 order", v, e);
    end
    read_byte(v); chk("R7 wrap to chunk0 byte1", v, grp_a[0]);
    read_byte(v); read_byte(v); read_byte(v); read_byte(v); read_byte(v);

    // R6: bytes after the 512th are ignored
    wr_mode(2'b01);
    for (int i = 0; i < 5; i++) push(8'h13, 1'b0, 1'b0);
    wr_mode(2'b00);
    wr_mode(2'b10);
    for (int p = 0; p < 6; p++) begin
      read_byte(v); chk("R6 overflow ignored", v, grp_a[p]);
    end

    // R5: erased page gives all-ones parity
    arm();
    for (int i = 0; i < 512; i++) push(8'hFF, 1'b0, 1'b0);
    wr_mode(2'b00);
    wr_mode(2'b10);
    for (int p = 0; p < 6; p++) begin
      read_byte(v); chk("R5 erased page", v, 8'hFF);
    end

    // R10: single flipped bit (byte 37, bit 3) gives an 11-bit syndrome locating it
    arm();
    for (int i = 0; i < 256; i++) push(8'(i ^ 8'h5A), 1'b0, 1'b0);
    wr_mode(2'b00); wr_mode(2'b10);
    for (int p = 0; p < 3; p++) read_byte(s0[p]);
    arm();
    for (int i = 0; i < 256; i++) push(8'(i ^ 8'h5A) ^ ((i == 37) ? 8'h08 : 8'h00), 1'b0, 1'b0);
    wr_mode(2'b00); wr_mode(2'b10);
    for (int p = 0; p < 3; p++) read_byte(s1[p]);
    begin
      logic [15:0] lx;
      logic [5:0] cx;
      logic [7:0] idx;
      logic [2:0] bpos;
      lx = {s0[0] ^ s1[0], s0[1] ^ s1[1]};
      cx = s0[2][7:2] ^ s1[2][7:2];
      for (int k = 0; k < 8; k++) idx[k] = lx[2*k+1];
      for (int k = 0; k < 3; k++) bpos[k] = cx[2*k+1];
      chk("R10 syndrome weight", 8'($countones({lx, cx})), 8'd11);
      chk("R10 byte index", idx, 8'd37);
      chk("R10 bit index", {5'd0, bpos}, 8'd3);
      chk("R5 pad bits", {6'd0, s1[2][1:0]}, 8'h03);
    end

    wr_mode(2'b00);
    @(negedge clk);
    finish_run();
  end
endmodule